// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial slave on a two-wire bus (clock and open-drain data) that lets a host read and write a small bank of 8-bit configuration registers. It oversamples both bus lines with the system clock and detects start, repeated start and stop conditions. It decodes the 7-bit slave address and a command code, drives acknowledge bits, and shifts read data out MSB first. It never drives the data line high: it only asserts a pull-low enable.

Bit 7 of the command code picks between two access styles. When the bit is 1, the access is indexed: the low seven bits name one register for a byte write or a byte read. When the bit is 0, the access is sequential: a block write carries a byte count and then data for registers 0, 1, 2 and so on, and a block read returns a byte count and then the registers in rising order. The register contents and their power-up defaults leave the block as flat vectors that feed output-enable and stop-control logic downstream.

Top module: `smbus_cfg_slave`

## Requirements
- R1: While reset is held and right after it, register 0 holds FFh, register 1 holds FEh, register 2 holds FFh and register 3 holds 00h, and sda_oe is low. Register k is bits [8k+7:8k] of cfg_regs.
- R2: An address byte whose upper seven bits are 1101001 (D2h for write, D3h for read) is acknowledged by pulling SDA low during the ninth clock. Any other address is not acknowledged, and SDA then stays released until a stop, even across repeated starts.
- R3: A byte write (command bit 7 = 1, bits 6:0 = offset, then one data byte) stores the data in the register at that offset. Every byte is acknowledged.
- R4: A byte read (command with bit 7 = 1, repeated start, address D3h) returns the register at the offset, MSB first.
- R5: A block write (command 00h, then a count byte, then data) acknowledges the count and does not store it. It writes data bytes to registers 0, 1, 2 and so on in order. A stop after any byte keeps the earlier writes. Bytes beyond the last register are acknowledged and discarded.
- R6: A block read (command 00h, repeated start, D3h) returns the count 4 first and then registers 0 upward. Bytes past the last register read as 00h. A master ACK continues the read. A master NACK leaves SDA released.
- R7: A byte write to an offset of 4 or more is acknowledged and changes no register. A byte read of such an offset returns 00h.
- R8: A written value appears on cfg_regs only after SCL falls at the end of the acknowledge clock of its data byte, and not during that clock's high phase.
- R9: sda_oe rises only while the synchronized SCL is low, and sda_oe is low after a stop.
- R10: cfg_dflt always presents the power-up defaults, whatever has been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 = pull the data line low |
| cfg_regs | output | NREG*8 | Current register contents, register k in bits [8k+7:8k] |
| cfg_dflt | output | NREG*8 | Power-up defaults, same layout |

## Verification
The bench mixes directed transfers with about forty random transfers. The random transfers draw the kind of access, offsets that include unimplemented ones, block lengths that run past the register bank, and random data. Each transfer is compared against a bench register model. Block reads longer than the bank separate the count byte, the sequential pointer and the fill value. A foreign address followed by a repeated start to the right address shows whether the ignore state lasts until stop. A write whose acknowledge clock is split into phases tells an early register update from one that waits for the acknowledge to finish.

// File: rtl/smbus_cfg_pkg.sv
package smbus_cfg_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RX_ACK,
      ST_TX,
      ST_TX_ACK,
      ST_HOLD,
      ST_IGNORE
   } bus_state_t;

   typedef enum logic [1:0] {
      K_ADDR,
      K_CMD,
      K_WDATA
   } rx_kind_t;

   localparam int IDX_W = 7;
endpackage

// File: rtl/smbus_cfg_linesync.sv
module smbus_cfg_linesync #(
   parameter int STAGES = 2,
   parameter bit FILTER = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_pipe, sda_pipe;
   logic scl_lvl, sda_lvl;
   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      end
   end

   generate
      if (FILTER) begin : g_filt
         logic scl_f, sda_f;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_f <= 1'b1;
               sda_f <= 1'b1;
            end else begin
               if (scl_pipe[STAGES-1] == scl_pipe[STAGES-2]) scl_f <= scl_pipe[STAGES-1];
               if (sda_pipe[STAGES-1] == sda_pipe[STAGES-2]) sda_f <= sda_pipe[STAGES-1];
            end
         end
         assign scl_lvl = scl_f;
         assign sda_lvl = sda_f;
      end else begin : g_direct
         assign scl_lvl = scl_pipe[STAGES-1];
         assign sda_lvl = sda_pipe[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_lvl;
         sda_d <= sda_lvl;
      end
   end

   assign scl_s     = scl_lvl;
   assign sda_s     = sda_lvl;
   assign scl_rise  = scl_lvl & ~scl_d;
   assign scl_fall  = ~scl_lvl & scl_d;
   assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
   assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/smbus_cfg_regbank.sv
module smbus_cfg_regbank
   import smbus_cfg_pkg::*;
#(
   parameter int               NREG     = 4,
   parameter logic [NREG*8-1:0] DEFAULTS = '0,
   parameter logic [7:0]        FILL     = 8'h00
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [7:0]       wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [7:0]       rd_data,
   output logic [NREG*8-1:0] regs_q
);
   generate
      for (genvar g = 0; g < NREG; g++) begin : g_reg
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= DEFAULTS[g*8 +: 8];
            else if (wr_en && (wr_idx == IDX_W'(g))) q <= wr_data;
         end
         assign regs_q[g*8 +: 8] = q;
      end
   endgenerate

   always_comb begin
      rd_data = FILL;
      for (int i = 0; i < NREG; i++) begin
         if (rd_idx == IDX_W'(i)) rd_data = regs_q[i*8 +: 8];
      end
   end
endmodule

// File: rtl/smbus_cfg_fsm.sv
module smbus_cfg_fsm
   import smbus_cfg_pkg::*;
#(
   parameter int         NREG  = 4,
   parameter logic [6:0] ADDR7 = 7'h69
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             start_det,
   input  logic             stop_det,
   input  logic             sda_s,
   input  logic [7:0]       rd_data,
   output logic [IDX_W-1:0] rd_idx,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_idx,
   output logic [7:0]       wr_data,
   output logic             sda_drv,
   output logic             addr_miss
);
   localparam logic [7:0] CNT_BYTE = 8'(NREG);

   bus_state_t       state;
   rx_kind_t         kind;
   logic [3:0]       bitcnt;
   logic [7:0]       sh;
   logic [7:0]       tx_sh;
   logic             blk_mode;
   logic [IDX_W-1:0] offset;
   logic [IDX_W-1:0] ptr;
   logic             cnt_pend;
   logic             mack;

   assign rd_idx    = blk_mode ? ptr : offset;
   assign addr_miss = (state == ST_IGNORE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         kind     <= K_ADDR;
         bitcnt   <= '0;
         sh       <= '0;
         tx_sh    <= '0;
         blk_mode <= 1'b0;
         offset   <= '0;
         ptr      <= '0;
         cnt_pend <= 1'b0;
         mack     <= 1'b1;
         sda_drv  <= 1'b0;
         wr_en    <= 1'b0;
         wr_idx   <= '0;
         wr_data  <= '0;
      end else begin
         wr_en <= 1'b0;
         if (stop_det) begin
            state   <= ST_IDLE;
            sda_drv <= 1'b0;
         end else if (start_det && state != ST_IGNORE) begin
            state   <= ST_RX;
            kind    <= K_ADDR;
            bitcnt  <= '0;
            sda_drv <= 1'b0;
         end else begin
            case (state)
               ST_RX: begin
                  if (scl_rise) begin
                     sh     <= {sh[6:0], sda_s};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall && bitcnt == 4'd8) begin
                     if (kind == K_ADDR && sh[7:1] != ADDR7) begin
                        state <= ST_IGNORE;
                     end else begin
                        state   <= ST_RX_ACK;
                        sda_drv <= 1'b1;
                     end
                  end
               end
               ST_RX_ACK: begin
                  if (scl_fall) begin
                     sda_drv <= 1'b0;
                     bitcnt  <= '0;
                     state   <= ST_RX;
                     case (kind)
                        K_ADDR: begin
                           if (sh[0]) begin
                              state <= ST_TX;
                              if (blk_mode) begin
                                 tx_sh   <= CNT_BYTE;
                                 sda_drv <= ~CNT_BYTE[7];
                                 ptr     <= '0;
                              end else begin
                                 tx_sh   <= rd_data;
                                 sda_drv <= ~rd_data[7];
                              end
                           end else begin
                              kind <= K_CMD;
                           end
                        end
                        K_CMD: begin
                           blk_mode <= ~sh[7];
                           offset   <= sh[6:0];
                           ptr      <= '0;
                           cnt_pend <= ~sh[7];
                           kind     <= K_WDATA;
                        end
                        default: begin
                           if (blk_mode && cnt_pend) begin
                              cnt_pend <= 1'b0;
                           end else begin
                              wr_en   <= 1'b1;
                              wr_data <= sh;
                              wr_idx  <= blk_mode ? ptr : offset;
                              if (blk_mode && ptr != '1) ptr <= ptr + 1'b1;
                           end
                        end
                     endcase
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall) begin
                     if (bitcnt == 4'd8) begin
                        sda_drv <= 1'b0;
                        state   <= ST_TX_ACK;
                     end else begin
                        tx_sh   <= {tx_sh[6:0], 1'b0};
                        sda_drv <= ~tx_sh[6];
                     end
                  end
               end
               ST_TX_ACK: begin
                  if (scl_rise) begin
                     mack <= sda_s;
                  end else if (scl_fall) begin
                     if (mack) begin
                        state <= ST_HOLD;
                     end else begin
                        tx_sh   <= rd_data;
                        sda_drv <= ~rd_data[7];
                        bitcnt  <= '0;
                        state   <= ST_TX;
                        if (blk_mode && ptr != '1) ptr <= ptr + 1'b1;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/smbus_cfg_slave.sv
module smbus_cfg_slave
   import smbus_cfg_pkg::*;
#(
   parameter int                NREG        = 4,
   parameter logic [6:0]        ADDR7       = 7'h69,
   parameter logic [NREG*8-1:0] DEFAULTS    = 32'h00FF_FEFF,
   parameter logic [7:0]        FILL        = 8'h00,
   parameter int                SYNC_STAGES = 2,
   parameter bit                FILTER      = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_in,
   input  logic             sda_in,
   output logic             sda_oe,
   output logic [NREG*8-1:0] cfg_regs,
   output logic [NREG*8-1:0] cfg_dflt
);
   generate
      if (NREG < 1 || NREG > 128) begin : g_bad_nreg
         $error("NREG must lie in 1..128");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic [IDX_W-1:0] rd_idx, wr_idx;
   logic [7:0]       rd_data, wr_data;
   logic             wr_en, sda_drv, addr_miss;

   smbus_cfg_linesync #(.STAGES(SYNC_STAGES), .FILTER(FILTER)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_in), .sda_i(sda_in),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   smbus_cfg_fsm #(.NREG(NREG), .ADDR7(ADDR7)) u_fsm (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
      .rd_data(rd_data), .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .sda_drv(sda_drv), .addr_miss(addr_miss)
   );

   smbus_cfg_regbank #(.NREG(NREG), .DEFAULTS(DEFAULTS), .FILL(FILL)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .regs_q(cfg_regs)
   );

   assign sda_oe   = sda_drv;
   assign cfg_dflt = DEFAULTS;
endmodule

// File: rtl/smbus_cfg_chk.sv
module smbus_cfg_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         scl_s,
   input logic         sda_oe,
   input logic         stop_det,
   input logic         addr_miss,
   input logic [W-1:0] cfg_regs,
   input logic [W-1:0] cfg_dflt
);
   // R1
   reset_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (cfg_regs == cfg_dflt && !sda_oe));

   // R2
   miss_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_miss |-> !sda_oe);

   // R8
   late_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_regs) |-> ($past(sda_oe, 2) && !$past(sda_oe)));

   // R9
   drive_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_s);

   // R9
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);
endmodule

bind smbus_cfg_slave smbus_cfg_chk #(.W(NREG*8)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
   .stop_det(stop_det), .addr_miss(addr_miss),
   .cfg_regs(cfg_regs), .cfg_dflt(cfg_dflt)
);

// File: tb/smbus_cfg_slave_test.sv
`timescale 1ns/1ps
module smbus_cfg_slave_test;
   localparam int Q = 10;
   localparam logic [7:0] AW = 8'hD2, AR = 8'hD3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic sda_oe;
   logic [31:0] cfg_regs, cfg_dflt;
   wire  sda_bus = sda_m & ~sda_oe;

   int n_chk = 0, n_bad = 0;
   logic [7:0] model [4];
   logic done = 1'b0;

   always #4 clk = ~clk;

   smbus_cfg_slave uut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
      .sda_oe(sda_oe), .cfg_regs(cfg_regs), .cfg_dflt(cfg_dflt)
   );

   function automatic logic [31:0] model_flat();
      return {model[3], model[2], model[1], model[0]};
   endfunction

   function automatic logic [7:0] model_rd(int idx);
      return (idx < 4) ? model[idx] : 8'h00;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic qw();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
   endtask

   task automatic put_bit(input logic b);
      sda_m = b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
   endtask

   task automatic get_bit(output logic b);
      sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); b = sda_bus; qw(); scl_m = 1'b0; qw();
   endtask

   task automatic send_byte(input logic [7:0] v, output bit acked);
      logic a;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(a);
      acked = !a;
   endtask

   task automatic recv_byte(input bit nack, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      put_bit(nack);
   endtask

   task automatic byte_wr(input int off, input logic [7:0] d);
      bit a0, a1, a2;
      bus_start();
      send_byte(AW, a0);
      send_byte({1'b1, 7'(off)}, a1);
      send_byte(d, a2);
      bus_stop();
      chk(a0 && a1 && a2, (off < 4) ? "R3 byte write acks" : "R7 unimplemented write acks",
          {29'd0, a0, a1, a2}, 32'd7);
      if (off < 4) model[off] = d;
      chk(cfg_regs == model_flat(), (off < 4) ? "R3 byte write contents" : "R7 no register change",
          cfg_regs, model_flat());
      chk(!sda_oe, "R9 released after stop", {31'd0, sda_oe}, 32'd0);
   endtask

   task automatic byte_rd(input int off);
      bit a0, a1, a2;
      logic [7:0] v;
      bus_start();
      send_byte(AW, a0);
      send_byte({1'b1, 7'(off)}, a1);
      bus_start();
      send_byte(AR, a2);
      recv_byte(1'b1, v);
      bus_stop();
      chk(a0 && a1 && a2, "R4 byte read acks", {29'd0, a0, a1, a2}, 32'd7);
      chk(v == model_rd(off), (off < 4) ? "R4 byte read data" : "R7 unimplemented read",
          {24'd0, v}, {24'd0, model_rd(off)});
   endtask

   task automatic blk_wr(input int n, input logic [7:0] cnt);
      bit a, all_ack;
      logic [7:0] d;
      all_ack = 1'b1;
      bus_start();
      send_byte(AW, a); all_ack &= a;
      send_byte(8'h00, a); all_ack &= a;
      send_byte(cnt, a); all_ack &= a;
      for (int i = 0; i < n; i++) begin
         d = 8'($urandom);
         send_byte(d, a); all_ack &= a;
         if (i < 4) model[i] = d;
      end
      bus_stop();
      chk(all_ack, "R5 block write acks", {31'd0, all_ack}, 32'd1);
      chk(cfg_regs == model_flat(), "R5 block write contents", cfg_regs, model_flat());
   endtask

   task automatic blk_rd(input int n);
      bit a0, a1, a2;
      logic [7:0] v;
      bus_start();
      send_byte(AW, a0);
      send_byte(8'h00, a1);
      bus_start();
      send_byte(AR, a2);
      chk(a0 && a1 && a2, "R6 block read acks", {29'd0, a0, a1, a2}, 32'd7);
      recv_byte(n == 0, v);
      chk(v == 8'd4, "R6 block read count", {24'd0, v}, 32'd4);
      for (int i = 0; i < n; i++) begin
         recv_byte(i == n - 1, v);
         chk(v == model_rd(i), "R6 block read data", {24'd0, v}, {24'd0, model_rd(i)});
      end
      chk(!sda_oe, "R6 released after master NACK", {31'd0, sda_oe}, 32'd0);
      bus_stop();
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      bit a;
      logic [7:0] old0;
      int op;
      void'($urandom(32'd2024));
      model[0] = 8'hFF; model[1] = 8'hFE; model[2] = 8'hFF; model[3] = 8'h00;
      repeat (5) @(negedge clk);
      chk(cfg_regs == 32'h00FF_FEFF, "R1 reset contents (in reset)", cfg_regs, 32'h00FF_FEFF);
      chk(!sda_oe, "R1 sda released in reset", {31'd0, sda_oe}, 32'd0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(cfg_regs == 32'h00FF_FEFF, "R1 reset contents", cfg_regs, 32'h00FF_FEFF);
      chk(cfg_dflt == 32'h00FF_FEFF, "R10 defaults output", cfg_dflt, 32'h00FF_FEFF);

      // R2: foreign address, then repeated start to own address while ignored
      bus_start();
      send_byte(8'hA4, a);
      chk(!a, "R2 foreign address not acked", {31'd0, a}, 32'd0);
      bus_start();
      send_byte(AW, a);
      chk(!a, "R2 ignored until stop", {31'd0, a}, 32'd0);
      bus_stop();
      bus_start();
      send_byte(AW, a);
      chk(a, "R2 own address acked after stop", {31'd0, a}, 32'd1);
      bus_stop();

      // R8: split acknowledge clock of a byte write to register 0
      old0 = cfg_regs[7:0];
      bus_start();
      send_byte(AW, a);
      send_byte(8'h80, a);
      for (int i = 7; i >= 0; i--) put_bit(8'h5A >> i);
      sda_m = 1'b1; qw(); scl_m = 1'b1; qw();
      chk(!sda_bus, "R8 data byte acked", {31'd0, sda_bus}, 32'd0);
      qw(); qw();
      chk(cfg_regs[7:0] == old0, "R8 no update before ack ends", {24'd0, cfg_regs[7:0]}, {24'd0, old0});
      scl_m = 1'b0; qw();
      chk(cfg_regs[7:0] == 8'h5A, "R8 update after ack ends", {24'd0, cfg_regs[7:0]}, 32'h5A);
      bus_stop();
      model[0] = 8'h5A;

      // R7 directed, R4, R5 partial, R6 past end
      byte_wr(5, 8'h3C);
      byte_rd(5);
      byte_wr(2, 8'hC3);
      byte_rd(2);
      blk_wr(2, 8'd4);
      blk_wr(6, 8'd6);
      blk_rd(6);
      blk_rd(0);

      for (int k = 0; k < 40; k++) begin
         op = int'($urandom % 4);
         case (op)
            0: byte_wr(int'($urandom % 6), 8'($urandom));
            1: byte_rd(int'($urandom % 6));
            2: blk_wr(int'($urandom % 6) + 1, 8'($urandom));
            default: blk_rd(int'($urandom % 6) + 1);
         endcase
      end

      chk(cfg_dflt == 32'h00FF_FEFF, "R10 defaults unchanged by writes", cfg_dflt, 32'h00FF_FEFF);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule